// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is a 16-bit free-running timer with a single output compare channel. Software reaches it over a byte-wide register bus. The oscillator clock is divided by two to form an internal clock. The counter moves forward once every fourth internal clock, which is once every eighth oscillator clock. The comparison against the programmed compare value runs only on that same tick.

Software loads the 16-bit compare value as two bytes. When the counter holds that value on a tick, the compare pin takes a level that software chose in the control register. The same event sets a compare flag in the status register. If the interrupt enable in the control register is set, the flag also raises the timer interrupt request. A write to the high byte holds off matches until the low byte follows, so a half-written value never fires. The flag is cleared by a two-step sequence: a status read while the flag is up, then an access to the low compare byte.

Top module: `tmr_ocmp_unit`

## Requirements
- R1: After reset, cmp_pin and tmr_irq are 0. The control (0x12) and status (0x13) registers read 0x00, both compare bytes (0x16 high, 0x17 low) read 0xFF, and the counter starts at 0xFFFC.
- R2: The internal reset is released 2 oscillator edges after rst_n rises. From then on the counter advances by one on every eighth oscillator edge, the first advance falling on the eighth edge.
- R3: The compare high byte at 0x16 and the low byte at 0x17 read back the last value written to them.
- R4: The compare check runs only on a tick edge. On a tick where the counter value held before the advance equals the compare value, cmp_pin takes control bit 0 (output level) at that edge, and at no other edge.
- R5: cmp_pin keeps its level between matches. A match whose level equals the present pin level leaves the pin unchanged; it does not toggle.
- R6: A match sets the compare flag, which is bit 6 of the status register at 0x13.
- R7: tmr_irq equals the compare flag ANDed with control bit 7 (interrupt enable), and follows a change of either one in the next cycle.
- R8: Reading the status register while the flag is 1 arms a clear. The next read or write of 0x17 then clears the flag. An access to 0x17 that is not armed leaves the flag set.
- R9: When an armed clear and a match fall on the same edge, the flag stays set, and the arm is used up.
- R10: A write to 0x16 blocks matches until 0x17 is written. Matches are also blocked from reset until the first write to 0x17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, one oscillator cycle per write |
| bus_rd | input | 1 | Read strobe, one oscillator cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| cmp_pin | output | 1 | Compare output pin |
| tmr_irq | output | 1 | Timer interrupt request |

## Verification
The assertions assume that bus_rd and bus_wr are never high together, and that each access is a one-cycle strobe. They also assume the address stays stable while a strobe is high. The bench drives every access through a pair of tasks that keep to this rule. It also picks each compare value several ticks ahead of the counter, so the write that completes it always lands before the tick it targets. It only places a bus access on a tick edge on purpose, in the one scenario that tests a clear and a match on the same edge.

// File: rtl/tmr_ocmp_pkg.sv
package tmr_ocmp_pkg;
  localparam int unsigned REG_AW = 8;

  // Register offsets; software depends on these.
  localparam logic [REG_AW-1:0] OFS_CTRL = 8'h12;
  localparam logic [REG_AW-1:0] OFS_STAT = 8'h13;
  localparam logic [REG_AW-1:0] OFS_CMPH = 8'h16;
  localparam logic [REG_AW-1:0] OFS_CMPL = 8'h17;

  // Bit positions inside the control and status bytes.
  localparam int unsigned CTRL_IE_BIT   = 7;
  localparam int unsigned CTRL_LVL_BIT  = 0;
  localparam int unsigned STAT_FLAG_BIT = 6;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_sn,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;

  assign tick_o = (pre_q == LAST);

  always_comb begin
    if (tick_o) pre_d = '0;
    else        pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/tmr_free_cnt.sv
module tmr_free_cnt #(
  parameter int unsigned      CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= RST_VAL;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !tick_i |=> $stable(cnt_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_sn)
    tick_i |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/tmr_ocmp_core.sv
module tmr_ocmp_core
  import tmr_ocmp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cmp_pin_o,
  output logic              irq_o
);
  logic              ie_q, ie_d;
  logic              lvl_q, lvl_d;
  logic [DATA_W-1:0] hi_q, hi_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  logic              inh_q, inh_d;
  logic              flag_q, flag_d;
  logic              arm_q, arm_d;
  logic              pin_q, pin_d;

  logic wr_ctrl, wr_hi, wr_lo, rd_stat, acc_lo, match_hit;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_hi   = bus_wr && (bus_addr == OFS_CMPH);
  assign wr_lo   = bus_wr && (bus_addr == OFS_CMPL);
  assign rd_stat = bus_rd && (bus_addr == OFS_STAT);
  assign acc_lo  = (bus_wr || bus_rd) && (bus_addr == OFS_CMPL);

  assign match_hit = tick_i && !inh_q && (cnt_i == {hi_q, lo_q});

  always_comb begin
    ie_d   = ie_q;
    lvl_d  = lvl_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    inh_d  = inh_q;
    arm_d  = arm_q;
    flag_d = flag_q;
    pin_d  = pin_q;
    if (wr_ctrl) begin
      ie_d  = bus_wdata[CTRL_IE_BIT];
      lvl_d = bus_wdata[CTRL_LVL_BIT];
    end
    if (wr_hi) begin
      hi_d  = bus_wdata;
      inh_d = 1'b1;
    end
    if (wr_lo) begin
      lo_d  = bus_wdata;
      inh_d = 1'b0;
    end
    if (rd_stat && flag_q) arm_d = 1'b1;
    else if (acc_lo)       arm_d = 1'b0;
    if (match_hit)            flag_d = 1'b1;
    else if (acc_lo && arm_q) flag_d = 1'b0;
    if (match_hit) pin_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ie_q   <= 1'b0;
      lvl_q  <= 1'b0;
      hi_q   <= '1;
      lo_q   <= '1;
      inh_q  <= 1'b1;
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      lvl_q  <= lvl_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      inh_q  <= inh_d;
      arm_q  <= arm_d;
      flag_q <= flag_d;
      pin_q  <= pin_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[CTRL_IE_BIT]  = ie_q;
        bus_rdata[CTRL_LVL_BIT] = lvl_q;
      end
      OFS_STAT: bus_rdata[STAT_FLAG_BIT] = flag_q;
      OFS_CMPH: bus_rdata = hi_q;
      OFS_CMPL: bus_rdata = lo_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign cmp_pin_o = pin_q;
  assign irq_o     = flag_q && ie_q;

  AST_PIN_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_sn)
    !tick_i |=> $stable(pin_q)); // R4
  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick_i && !inh_q && (cnt_i == {hi_q, lo_q})) |=> flag_q); // R6
  AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_sn)
    inh_q |=> ($stable(pin_q) && !$rose(flag_q))); // R10
  AST_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(flag_q) |-> $past(arm_q)); // R8
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_sn)
    !(bus_wr && bus_rd)); // R8
endmodule

// File: rtl/tmr_ocmp_unit.sv
module tmr_ocmp_unit
  import tmr_ocmp_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TICK_DIV  = 8,
  parameter int unsigned SYNC_STG  = 2,
  parameter int unsigned CNT_RST   = 'hFFFC,
  localparam int unsigned CNT_W    = 2 * DATA_W
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cmp_pin,
  output logic              tmr_irq
);
  logic             rst_sn;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  tmr_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk    (clk_osc),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  tmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk_osc),
    .rst_sn (rst_sn),
    .tick_o (tick)
  );

  tmr_free_cnt #(.CNT_W(CNT_W), .RST_VAL(CNT_W'(CNT_RST))) u_cnt (
    .clk    (clk_osc),
    .rst_sn (rst_sn),
    .tick_i (tick),
    .cnt_o  (cnt)
  );

  tmr_ocmp_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk_osc),
    .rst_sn    (rst_sn),
    .tick_i    (tick),
    .cnt_i     (cnt),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmp_pin_o (cmp_pin),
    .irq_o     (tmr_irq)
  );
endmodule

// File: tb/tmr_ocmp_unit_tb_top.sv
module tmr_ocmp_unit_tb_top;
  localparam time CLK_PER = 10ns;

  logic       clk_osc;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cmp_pin;
  logic       tmr_irq;

  int n_chk = 0;
  int n_err = 0;
  int ecount = 0;
  logic [7:0] rv;

  tmr_ocmp_unit dut_i (
    .clk_osc   (clk_osc),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmp_pin   (cmp_pin),
    .tmr_irq   (tmr_irq)
  );

  initial clk_osc = 1'b0;
  always #(CLK_PER/2) clk_osc = ~clk_osc;

  // Oscillator edges counted since rst_n rose.
  always @(posedge clk_osc) begin
    if (rst_n) ecount <= ecount + 1;
    else       ecount <= 0;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at edge %0d", req, act, exp, ecount);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_osc);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk_osc);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_osc);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk_osc);
    bus_rd = 1'b0;
  endtask

  task automatic wait_edge(input int e);
    while (ecount < e) @(negedge clk_osc);
  endtask

  // Counter value after the current edge: reset value 0xFFFC, first step at edge 10.
  function automatic logic [15:0] cur_val();
    int t;
    t = (ecount >= 2) ? (ecount - 2) / 8 : 0;
    return 16'hFFFC + 16'(t);
  endfunction

  // Edge on which a compare value v matches.
  function automatic int hit_edge(input logic [15:0] v);
    logic [15:0] j;
    j = v - 16'hFFFB;
    return 2 + 8 * int'(j);
  endfunction

  task automatic write_cmp(input logic [15:0] v);
    bus_write(8'h16, v[15:8]);
    bus_write(8'h17, v[7:0]);
  endtask

  task automatic do_match(input logic [7:0] ctrl);
    logic [15:0] v;
    bus_write(8'h12, ctrl);
    v = cur_val() + 16'd4;
    write_cmp(v);
    wait_edge(hit_edge(v));
  endtask

  task automatic t_reset();
    chk("R1 pin", {15'd0, cmp_pin}, 16'd0);
    chk("R1 irq", {15'd0, tmr_irq}, 16'd0);
    bus_read(8'h12, rv); chk("R1 ctrl", {8'd0, rv}, 16'h0000);
    bus_read(8'h13, rv); chk("R1 stat", {8'd0, rv}, 16'h0000);
    bus_read(8'h16, rv); chk("R1 cmp hi", {8'd0, rv}, 16'h00FF);
    bus_read(8'h17, rv); chk("R1 cmp lo", {8'd0, rv}, 16'h00FF);
    // Reset compare 0xFFFF would hit at edge 34 if not blocked.
    wait_edge(50);
    bus_read(8'h13, rv); chk("R10 blocked from reset", {8'd0, rv}, 16'h0000);
  endtask

  task automatic t_cmp_rw();
    bus_write(8'h16, 8'hA5);
    bus_write(8'h17, 8'h3C);
    bus_read(8'h16, rv); chk("R3 hi readback", {8'd0, rv}, 16'h00A5);
    bus_read(8'h17, rv); chk("R3 lo readback", {8'd0, rv}, 16'h003C);
  endtask

  task automatic t_match();
    logic [15:0] v;
    int e;
    bus_write(8'h12, 8'h01);
    v = cur_val() + 16'd4;
    e = hit_edge(v);
    write_cmp(v);
    wait_edge(e - 1);
    chk("R4 pin before tick", {15'd0, cmp_pin}, 16'd0);
    wait_edge(e);
    chk("R2 R4 pin at tick edge", {15'd0, cmp_pin}, 16'd1);
    chk("R7 irq off when disabled", {15'd0, tmr_irq}, 16'd0);
    bus_read(8'h13, rv); chk("R6 flag set", {8'd0, rv}, 16'h0040);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    int e;
    wait_edge(ecount + 24);
    chk("R5 pin holds", {15'd0, cmp_pin}, 16'd1);
    do_match(8'h01);
    chk("R5 same level no toggle", {15'd0, cmp_pin}, 16'd1);
    bus_write(8'h12, 8'h00);
    v = cur_val() + 16'd4;
    e = hit_edge(v);
    write_cmp(v);
    wait_edge(e - 1);
    chk("R4 pin before low match", {15'd0, cmp_pin}, 16'd1);
    wait_edge(e);
    chk("R4 pin takes low level", {15'd0, cmp_pin}, 16'd0);
  endtask

  task automatic t_irq_clear();
    do_match(8'h00);
    chk("R7 irq off, enable low", {15'd0, tmr_irq}, 16'd0);
    bus_write(8'h12, 8'h80);
    chk("R7 irq follows enable", {15'd0, tmr_irq}, 16'd1);
    bus_read(8'h17, rv);
    chk("R8 unarmed access keeps flag", {15'd0, tmr_irq}, 16'd1);
    bus_read(8'h13, rv);
    bus_read(8'h17, rv);
    chk("R8 armed access clears irq", {15'd0, tmr_irq}, 16'd0);
    bus_read(8'h13, rv); chk("R8 flag cleared", {8'd0, rv}, 16'h0000);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    int e;
    do_match(8'h80);
    chk("R7 irq with enable", {15'd0, tmr_irq}, 16'd1);
    v = cur_val() + 16'd4;
    e = hit_edge(v);
    write_cmp(v);
    bus_read(8'h13, rv);
    wait_edge(e - 1);
    bus_addr = 8'h17; bus_rd = 1'b1;
    @(negedge clk_osc);
    bus_rd = 1'b0;
    chk("R9 set wins over clear", {15'd0, tmr_irq}, 16'd1);
    bus_read(8'h17, rv);
    chk("R9 arm used up", {15'd0, tmr_irq}, 16'd1);
    bus_read(8'h13, rv);
    bus_read(8'h17, rv);
    chk("R8 clear after priority", {15'd0, tmr_irq}, 16'd0);
  endtask

  task automatic t_inhibit();
    logic [15:0] v;
    int e;
    bus_write(8'h12, 8'h81);
    v = cur_val() + 16'd4;
    e = hit_edge(v);
    write_cmp(v);
    bus_write(8'h16, v[15:8]);
    wait_edge(e + 8);
    chk("R10 pin blocked after hi write", {15'd0, cmp_pin}, 16'd0);
    chk("R10 flag blocked after hi write", {15'd0, tmr_irq}, 16'd0);
    v = cur_val() + 16'd4;
    e = hit_edge(v);
    write_cmp(v);
    wait_edge(e);
    chk("R10 lo write re-enables match", {15'd0, cmp_pin}, 16'd1);
    chk("R10 R7 irq after re-enable", {15'd0, tmr_irq}, 16'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_osc);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = 8'h00; bus_wdata = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (4) @(negedge clk_osc);
    rst_n = 1'b1;
    wait_edge(4);
    t_reset();
    t_cmp_rw();
    t_match();
    t_hold();
    t_irq_clear();
    t_priority();
    t_inhibit();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule